// File: doc/BRIEF.md
# Fault Input Status Register

This block records the condition of four fault lines that feed a PWM generator and presents it to software as a 16-bit register on a simple single-cycle register port. Each raw line first passes through a two-flop synchronizer. A per-line polarity bit then turns the pin level into an "active" condition. Only that adjusted condition is ever reported or recorded, never the raw pin level.

A mode input selects how the four status bits behave.

- **Live view (mode 0):** the register returns the present adjusted levels and cannot be written.
- **Sticky view (mode 1):** each bit sets once its adjusted line has been active and stays set until software clears it. Software clears a bit by writing 1 to it.

Clearing also requires the extended-fault-source enable. A status bit is kept for every line, whether or not the generator uses that line as a fault source.

Bus accesses are decoded each cycle into one of four named operations:

- `OP_IDLE`: no access.
- `OP_READ`: read only.
- `OP_WRITE`: write only.
- `OP_BOTH`: read and write together.

Decoding uses a unique case. The register has no sequencing beyond this decode, so there are no multi-cycle states.

Top module: `fault_status_reg`

## Requirements
- R1: Read data bits 15:4 always read 0, and writes to them have no effect. Bits 3:0 carry the status of fault lines 3:0, one bit per line at the same index.
- R2: After reset, all sticky status bits are 0 and read data is 0.
- R3: When `latch_mode` is 0, a read returns the current adjusted fault levels, and a write changes nothing.
- R4: When `latch_mode` is 1, a status bit becomes 1 on the first clock edge that sees its adjusted line active. It stays 1 after the line returns inactive.
- R5: In sticky view with the enable set, writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R6: Each line is synchronized through two flops and then XORed with its `fault_pol` bit, where 1 means active-low. Status reflects only this adjusted value.
- R7: When `ext_src_en` is 0, writes have no effect on any status bit.
- R8: When a bit's adjusted line is active in the same cycle that a write of 1 clears it, the bit stays 1.
- R9: Moving to live view neither clears nor records sticky bits. On return to sticky view, the bits read as they were before the move.
- R10: `rdata` is loaded on the clock edge where `rd_en` is 1 and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_raw | input | 4 | Raw fault lines, asynchronous |
| fault_pol | input | 4 | Per-line polarity, 1 = active-low |
| latch_mode | input | 1 | 0 = live view, 1 = sticky view |
| ext_src_en | input | 1 | Extended fault source enable; gates writes |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |

## Verification
The assertions assume that the control inputs (`fault_pol`, `latch_mode`, `ext_src_en`) and the bus strobes are synchronous to `clk`. Only `fault_raw` is asynchronous. The sticky-retention property also assumes that no clear is issued in the cycle it checks.

The stimulus changes every input only on the falling edge. It holds fault levels for at least three cycles before sampling, so each level crosses the synchronizer and the sticky stage before any read that depends on it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int FSR_DATA_W = 16;
    localparam int FSR_LINES  = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_BOTH  = 2'b11
    } bus_op_e;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    input  logic [N-1:0] pol,
    output logic [N-1:0] adj_out
);
    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= raw_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Polarity adjustment after the final stage: 1 marks an active-low line
    always_comb adj_out = stage_q[STAGES-1] ^ pol;
endmodule

// File: rtl/fsr_sticky.sv
module fsr_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] sticky_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          sticky_q[i] <= 1'b0;
            else if (set_vec[i]) sticky_q[i] <= 1'b1;   // set has priority
            else if (clr_vec[i]) sticky_q[i] <= 1'b0;
        end

        // R4: a recorded activation is visible on the next cycle
        a_r4_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> sticky_q[i]);
        // R8: simultaneous set and clear leaves the bit at 1
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[i] && clr_vec[i]) |=> sticky_q[i]);
        // R7/R9: without a clear request a set bit never drops
        a_r7_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_vec[i] && sticky_q[i]) |=> sticky_q[i]);
    end
endmodule

// File: rtl/fsr_port.sv
module fsr_port
    import fsr_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [N-1:0]  wbits,
    input  logic          latch_mode,
    input  logic          ext_src_en,
    input  logic [N-1:0]  live_vec,
    input  logic [N-1:0]  sticky_vec,
    output logic [N-1:0]  clr_vec,
    output logic [DW-1:0] rdata
);
    bus_op_e      op;
    logic         do_read;
    logic         do_write;
    logic [N-1:0] view;

    always_comb op = bus_op_e'({wr_en, rd_en});

    always_comb begin
        do_read  = 1'b0;
        do_write = 1'b0;
        unique case (op)
            OP_IDLE:  ;
            OP_READ:  do_read = 1'b1;
            OP_WRITE: do_write = 1'b1;
            OP_BOTH: begin
                do_read  = 1'b1;
                do_write = 1'b1;
            end
        endcase
    end

    // Writes count only in sticky view with the enable set
    always_comb clr_vec = (do_write && latch_mode && ext_src_en) ? wbits : '0;
    always_comb view    = latch_mode ? sticky_vec : live_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata <= '0;
        else if (do_read) rdata <= {{(DW-N){1'b0}}, view};
    end

    // R1: reserved bits never read as 1
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:N] == '0);
    // R10: read data holds without a read strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    // R3: a live read returns the adjusted levels seen at the strobe
    a_r3_live_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !latch_mode) |=> rdata[N-1:0] == $past(live_vec));
    // R3/R7: no clear leaves this port in live view or with the enable off
    a_r7_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode || !ext_src_en) |-> clr_vec == '0);
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
    import fsr_pkg::*;
#(
    parameter int N  = FSR_LINES,
    parameter int DW = FSR_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  fault_raw,
    input  logic [N-1:0]  fault_pol,
    input  logic          latch_mode,
    input  logic          ext_src_en,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int SYNC_STAGES = 2;

    logic [N-1:0] adj;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;
    logic [N-1:0] sticky;
    logic         unused_hi;

    always_comb unused_hi = ^wdata[DW-1:N];

    fsr_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  (fault_raw),
        .pol     (fault_pol),
        .adj_out (adj)
    );

    // Recording happens only in sticky view
    always_comb set_vec = latch_mode ? adj : '0;

    fsr_sticky #(.N(N)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .sticky_q (sticky)
    );

    fsr_port #(.N(N), .DW(DW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wbits      (wdata[N-1:0]),
        .latch_mode (latch_mode),
        .ext_src_en (ext_src_en),
        .live_vec   (adj),
        .sticky_vec (sticky),
        .clr_vec    (clr_vec),
        .rdata      (rdata)
    );

    // R9: in live view the sticky bits keep their values
    a_r9_live_retains: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_mode |=> sticky == $past(sticky));
endmodule

// File: tb/test_fault_status_reg.sv
`timescale 1ns/1ps
module test_fault_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fault_raw = '0;
    logic [3:0]  fault_pol = '0;
    logic        latch_mode = 1'b0;
    logic        ext_src_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    fault_status_reg i_fault_status_reg (
        .clk(clk), .rst_n(rst_n), .fault_raw(fault_raw), .fault_pol(fault_pol),
        .latch_mode(latch_mode), .ext_src_en(ext_src_en), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(output logic [15:0] v);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_en = 1'b1; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic set_faults(input logic [3:0] f);
        fault_raw = f;
        cycles(3);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        do_read(v);
        check("R2 reset live", v, 16'h0000);
        latch_mode = 1'b1;
        do_read(v);
        check("R2 reset sticky", v, 16'h0000);
        latch_mode = 1'b0;
    endtask

    task automatic t_live;
        logic [15:0] v;
        set_faults(4'b1010);
        do_read(v);
        check("R3 live 1010", v, 16'h000A);
        set_faults(4'b0101);
        do_read(v);
        check("R3 live 0101", v, 16'h0005);
        ext_src_en = 1'b1;
        do_write(16'hFFFF);
        do_read(v);
        check("R3 live write ignored, R1 reserved zero", v, 16'h0005);
        set_faults(4'b0000);
        ext_src_en = 1'b0;
    endtask

    task automatic t_polarity;
        logic [15:0] v;
        fault_pol = 4'b0011;
        cycles(1);
        do_read(v);
        check("R6 active-low idle", v, 16'h0003);
        set_faults(4'b0001);
        do_read(v);
        check("R6 mixed polarity", v, 16'h0002);
        fault_pol = 4'b0000;
        set_faults(4'b0000);
    endtask

    task automatic t_sticky_w1c;
        logic [15:0] v;
        latch_mode = 1'b1;
        ext_src_en = 1'b1;
        set_faults(4'b0100);
        set_faults(4'b0000);
        do_read(v);
        check("R4 sticky holds after pulse", v, 16'h0004);
        do_write(16'hFFF0);
        do_read(v);
        check("R5 write zero keeps, R1", v, 16'h0004);
        do_write(16'h0004);
        do_read(v);
        check("R5 write one clears", v, 16'h0000);
    endtask

    task automatic t_enable;
        logic [15:0] v;
        set_faults(4'b0001);
        set_faults(4'b0000);
        ext_src_en = 1'b0;
        do_write(16'h000F);
        do_read(v);
        check("R7 write ignored when disabled", v, 16'h0001);
        ext_src_en = 1'b1;
        do_write(16'h0001);
        do_read(v);
        check("R7 write works when enabled", v, 16'h0000);
    endtask

    task automatic t_set_wins;
        logic [15:0] v;
        set_faults(4'b0010);
        do_write(16'h0002);
        do_read(v);
        check("R8 set wins over clear", v, 16'h0002);
        set_faults(4'b0000);
        do_write(16'h0002);
        do_read(v);
        check("R8 clears after line idle", v, 16'h0000);
    endtask

    task automatic t_mode_switch;
        logic [15:0] v;
        set_faults(4'b0001);
        set_faults(4'b0000);
        latch_mode = 1'b0;
        do_read(v);
        check("R9 live view after switch", v, 16'h0000);
        do_write(16'h000F);
        set_faults(4'b1000);
        set_faults(4'b0000);
        latch_mode = 1'b1;
        do_read(v);
        check("R9 sticky retained across live view", v, 16'h0001);
        do_write(16'h0001);
    endtask

    task automatic t_hold;
        logic [15:0] v;
        latch_mode = 1'b0;
        set_faults(4'b0110);
        do_read(v);
        check("R10 loaded on read", v, 16'h0006);
        set_faults(4'b1001);
        cycles(2);
        check("R10 holds without read", rdata, 16'h0006);
        fault_raw = 4'b0000;
    endtask

    initial begin
        cycles(2);
        check("R2 rdata in reset", rdata, 16'h0000);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_live();
        t_polarity();
        t_sticky_w1c();
        t_enable();
        t_set_wins();
        t_mode_switch();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule